// File: doc/BRIEF.md
# Conditional Trap Evaluator

This unit decides, for a processor's four interrupt-raising instructions, whether an interrupt should be taken and which type number it carries. Two of the instructions are conditional. A range-check instruction compares a 16-bit register value against a lower-limit word and an upper-limit word that have already been read from memory. An overflow-check instruction examines the overflow flag. The other two are unconditional: a software interrupt carrying an explicit type, and the one-byte breakpoint.

The execute stage presents one instruction per cycle, marked by `eval_valid`. It supplies an opcode selector, the operands, and the flag. One clock later the unit pulses `trap_valid` together with an 8-bit `trap_type`. An interrupt sequencer uses that pulse to start its push-flags, push-return-address and vector-fetch sequence. When a conditional instruction does not trap, the unit stays silent and execution continues with the next instruction.

Top module: `cond_trap_eval`

## Requirements
- R1: While `rst` is high at a clock edge, `trap_valid` and `trap_type` are 0 after that edge.
- R2: For a range check (`eval_op`=0), a value strictly below the lower limit word produces `trap_valid`=1 with `trap_type`=5.
- R3: For a range check, a value strictly above the upper limit word produces `trap_valid`=1 with `trap_type`=5.
- R4: For a range check, a value equal to either limit, or lying between them, produces no trap. Both ends of the range are inclusive.
- R5: Range comparisons treat the value and both limits as signed two's-complement numbers. For example, 0xFFFF (-1) lies inside the range -2..3.
- R6: An overflow check (`eval_op`=1) with `ovf_flag`=1 produces `trap_valid`=1 with `trap_type`=4.
- R7: An overflow check with `ovf_flag`=0 produces no trap, so it behaves as a no-op.
- R8: A breakpoint (`eval_op`=3) always produces `trap_valid`=1 with `trap_type`=3.
- R9: A software interrupt (`eval_op`=2) always produces `trap_valid`=1 with `trap_type` equal to `sw_type`, for any value from 0 to 255.
- R10: A result appears exactly one clock after the edge that samples `eval_valid`=1. `trap_valid` is high for one cycle per evaluated instruction that traps. Back-to-back instructions give back-to-back pulses.
- R11: When `eval_valid` is low, no trap is produced. `trap_type` is 0 whenever `trap_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eval_valid | input | 1 | An instruction is presented this cycle |
| eval_op | input | 2 | 0 range check, 1 overflow check, 2 software interrupt, 3 breakpoint |
| reg_val | input | 16 | Register value under range check |
| lo_word | input | 16 | Lower limit word (operand address) |
| hi_word | input | 16 | Upper limit word (operand address plus 2) |
| ovf_flag | input | 1 | Current overflow flag |
| sw_type | input | 8 | Type operand of the software interrupt |
| trap_valid | output | 1 | One-cycle trap request strobe |
| trap_type | output | 8 | Interrupt type number for the request |

## Verification
A fault in the comparator or the selection logic shows up at the ports one clock after the offending instruction. It appears as a missing pulse, an unwanted pulse, or a wrong type number. The pulse register holds no state longer than one cycle, so a corrupted value cannot persist unnoticed past the next evaluation. The stimulus therefore targets the values next to each limit, operands with the sign bit set, the overflow flag in both states, and runs of instructions with no gap between them.

// File: rtl/cond_trap_pkg.sv
package cond_trap_pkg;

    localparam int DATA_W = 16;
    localparam int TYPE_W = 8;

    typedef enum logic [1:0] {
        OP_RANGE = 2'd0,
        OP_OVCHK = 2'd1,
        OP_SWINT = 2'd2,
        OP_BRKPT = 2'd3
    } trap_op_e;

    localparam logic [TYPE_W-1:0] TYPE_RANGE = 8'd5;
    localparam logic [TYPE_W-1:0] TYPE_OVF   = 8'd4;
    localparam logic [TYPE_W-1:0] TYPE_BRK   = 8'd3;

    typedef struct packed {
        logic              fire;
        logic [TYPE_W-1:0] vec;
    } trap_req_t;

    function automatic trap_req_t make_req(input logic fire, input logic [TYPE_W-1:0] vec);
        trap_req_t r;
        r.fire = fire;
        r.vec  = fire ? vec : '0;
        return r;
    endfunction

endpackage

// File: rtl/cond_trap_range.sv
module cond_trap_range #(
    parameter int  W          = 16,
    parameter bit  SIGNED_CMP = 1'b1
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lower,
    input  logic [W-1:0] upper,
    output logic         below,
    output logic         above
);
    generate
        if (SIGNED_CMP) begin : g_signed
            always_comb begin
                below = $signed(value) < $signed(lower);
                above = $signed(value) > $signed(upper);
            end
        end else begin : g_unsigned
            always_comb begin
                below = value < lower;
                above = value > upper;
            end
        end
    endgenerate
endmodule

// File: rtl/cond_trap_select.sv
module cond_trap_select
    import cond_trap_pkg::*;
(
    input  logic              valid,
    input  trap_op_e          op,
    input  logic              below,
    input  logic              above,
    input  logic              ovf,
    input  logic [TYPE_W-1:0] swt,
    output trap_req_t         req
);
    always_comb begin
        req = make_req(1'b0, '0);
        if (valid) begin
            unique case (op)
                OP_RANGE: req = make_req(below | above, TYPE_RANGE);
                OP_OVCHK: req = make_req(ovf, TYPE_OVF);
                OP_SWINT: req = make_req(1'b1, swt);
                OP_BRKPT: req = make_req(1'b1, TYPE_BRK);
                default:  req = make_req(1'b0, '0);
            endcase
        end
    end
endmodule

// File: rtl/cond_trap_stage.sv
module cond_trap_stage
    import cond_trap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trap_req_t d,
    output trap_req_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/cond_trap_eval.sv
module cond_trap_eval
    import cond_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_valid,
    input  logic [1:0]        eval_op,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic              ovf_flag,
    input  logic [TYPE_W-1:0] sw_type,
    output logic              trap_valid,
    output logic [TYPE_W-1:0] trap_type
);
    trap_op_e  op_e;
    logic      lt_lo, gt_hi;
    trap_req_t nxt, cur;

    assign op_e = trap_op_e'(eval_op);

    cond_trap_range #(.W(DATA_W), .SIGNED_CMP(1'b1)) u_range (
        .value(reg_val), .lower(lo_word), .upper(hi_word),
        .below(lt_lo), .above(gt_hi)
    );

    cond_trap_select u_sel (
        .valid(eval_valid), .op(op_e), .below(lt_lo), .above(gt_hi),
        .ovf(ovf_flag), .swt(sw_type), .req(nxt)
    );

    cond_trap_stage u_stage (.clk(clk), .rst(rst), .d(nxt), .q(cur));

    assign trap_valid = cur.fire;
    assign trap_type  = cur.vec;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!trap_valid && trap_type == '0));
    // R4
    a_r4_inside_silent: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && op_e == OP_RANGE &&
         $signed(reg_val) >= $signed(lo_word) && $signed(reg_val) <= $signed(hi_word))
        |=> !trap_valid);
    // R6
    a_r6_overflow_trap: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && op_e == OP_OVCHK && ovf_flag) |=> (trap_valid && trap_type == 8'd4));
    // R7
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && op_e == OP_OVCHK && !ovf_flag) |=> !trap_valid);
    // R8
    a_r8_breakpoint: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && op_e == OP_BRKPT) |=> (trap_valid && trap_type == 8'd3));
    // R9
    a_r9_swint_type: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && op_e == OP_SWINT) |=> (trap_valid && trap_type == $past(sw_type)));
    // R11
    a_r11_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !eval_valid |=> !trap_valid);
    // R11
    a_r11_type_zero: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |-> trap_type == '0);
endmodule

// File: tb/tb_cond_trap_eval.sv
module tb_cond_trap_eval;
    logic        clk = 1'b0;
    logic        rst;
    logic        eval_valid;
    logic [1:0]  eval_op;
    logic [15:0] reg_val, lo_word, hi_word;
    logic        ovf_flag;
    logic [7:0]  sw_type;
    logic        trap_valid;
    logic [7:0]  trap_type;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic       v;
        logic [7:0] t;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    cond_trap_eval dut (
        .clk(clk), .rst(rst), .eval_valid(eval_valid), .eval_op(eval_op),
        .reg_val(reg_val), .lo_word(lo_word), .hi_word(hi_word),
        .ovf_flag(ovf_flag), .sw_type(sw_type),
        .trap_valid(trap_valid), .trap_type(trap_type)
    );

    task automatic check(input string req, input logic v, input logic [7:0] t);
        n_checks++;
        if (trap_valid !== v || trap_type !== t) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b type=%0d, expected valid=%0b type=%0d",
                     req, trap_valid, trap_type, v, t);
        end
    endtask

    // driver: applies one instruction per cycle and predicts the result
    task automatic drive(input string req, input logic vld, input logic [1:0] op,
                         input logic [15:0] val, input logic [15:0] lo, input logic [15:0] hi,
                         input logic of, input logic [7:0] swt);
        exp_t e;
        @(negedge clk);
        eval_valid = vld; eval_op = op; reg_val = val;
        lo_word = lo; hi_word = hi; ovf_flag = of; sw_type = swt;
        e.req = req;
        e.v = 1'b0; e.t = 8'd0;
        if (vld) begin
            case (op)
                2'd0: if ($signed(val) < $signed(lo) || $signed(val) > $signed(hi)) begin
                          e.v = 1'b1; e.t = 8'd5;
                      end
                2'd1: if (of) begin e.v = 1'b1; e.t = 8'd4; end
                2'd2: begin e.v = 1'b1; e.t = swt; end
                default: begin e.v = 1'b1; e.t = 8'd3; end
            endcase
        end
        sb.push_back(e);
    endtask

    // monitor: compares after each edge against the prediction from the prior drive
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, e.v, e.t);
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; eval_valid = 1'b1; eval_op = 2'd3;
        reg_val = 0; lo_word = 0; hi_word = 0; ovf_flag = 1'b1; sw_type = 8'hAA;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 8'd0);
        @(negedge clk); rst = 1'b0; eval_valid = 1'b0;
        // R2 below lower limit
        drive("R2 below", 1, 2'd0, 16'd9, 16'd10, 16'd20, 0, 0);
        drive("R2 far below", 1, 2'd0, 16'd0, 16'd100, 16'd200, 0, 0);
        // R3 above upper limit
        drive("R3 above", 1, 2'd0, 16'd21, 16'd10, 16'd20, 0, 0);
        drive("R3 max", 1, 2'd0, 16'h7FFF, 16'd10, 16'd20, 0, 0);
        // R4 inclusive ends and middle
        drive("R4 eq lower", 1, 2'd0, 16'd10, 16'd10, 16'd20, 0, 0);
        drive("R4 eq upper", 1, 2'd0, 16'd20, 16'd10, 16'd20, 0, 0);
        drive("R4 inside", 1, 2'd0, 16'd15, 16'd10, 16'd20, 0, 0);
        drive("R4 single point", 1, 2'd0, 16'd7, 16'd7, 16'd7, 0, 0);
        // R5 signed compare
        drive("R5 neg inside", 1, 2'd0, 16'hFFFF, 16'hFFFE, 16'd3, 0, 0);
        drive("R5 neg below", 1, 2'd0, 16'h8000, 16'hFFFE, 16'd3, 0, 0);
        drive("R5 pos above neg range", 1, 2'd0, 16'd1, 16'hFFF0, 16'hFFFF, 0, 0);
        drive("R5 neg vs pos lower", 1, 2'd0, 16'hFFFF, 16'd0, 16'd5, 0, 0);
        // R6 / R7 overflow check
        drive("R6 of set", 1, 2'd1, 16'd0, 16'd0, 16'd0, 1, 0);
        drive("R7 of clear", 1, 2'd1, 16'd0, 16'd0, 16'd0, 0, 0);
        drive("R7 of clear, range data out", 1, 2'd1, 16'd50, 16'd0, 16'd1, 0, 0);
        // R8 breakpoint
        drive("R8 brk", 1, 2'd3, 16'd0, 16'd0, 16'd0, 0, 8'd77);
        // R9 software interrupt
        drive("R9 int 0", 1, 2'd2, 16'd0, 16'd0, 16'd0, 0, 8'd0);
        drive("R9 int 255", 1, 2'd2, 16'd0, 16'd0, 16'd0, 0, 8'd255);
        drive("R9 int 0x21", 1, 2'd2, 16'd0, 16'd0, 16'd0, 0, 8'h21);
        // R10 back-to-back then single pulse
        drive("R10 b2b 1", 1, 2'd3, 0, 0, 0, 0, 0);
        drive("R10 b2b 2", 1, 2'd1, 0, 0, 0, 1, 0);
        drive("R10 pulse end", 0, 2'd3, 0, 0, 0, 1, 0);
        // R11 idle with trapping operands
        drive("R11 idle brk", 0, 2'd3, 0, 0, 0, 1, 8'd9);
        drive("R11 idle swint", 0, 2'd2, 0, 0, 0, 1, 8'd9);
        drive("R11 idle range out", 0, 2'd0, 16'd99, 16'd0, 16'd1, 1, 0);
        for (int i = 0; i < 40; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h0D37);
            drive("R5 sweep", 1, 2'd0, v, 16'hF000, 16'h1000, 0, 0);
        end
        drive("R11 drain", 0, 2'd0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule